// File: doc/BRIEF.md
# Modulo Alarm Timer

A 16-bit up-counter, set up through a small 32-bit register bus, that acts as a one-shot alarm. The counter advances on pulses from a power-of-two prescaler. The prescaler is fed either by the system clock or by a fixed-frequency clock-enable tick. It climbs from a programmable initial value to a programmable modulo value. On the next count it goes back to the initial value and sets an overflow flag. That flag, gated by an enable bit, drives a level interrupt.

Software arms an alarm in four steps: write the modulo value, load the counter by writing the count register, select a clock source and divider, and set the interrupt enable. It acknowledges the alarm by reading the control word with the flag set, then writing the flag bit as zero. An overflow that arrives after that read defeats the acknowledge, so no alarm is lost.

The bus has no back-pressure. An access is taken whenever `bus_req` is high, and there is no ready signal. `bus_rdata` always shows the register selected by `bus_addr`. A read takes effect only when `bus_req` is high and `bus_we` is low.

Top module: `mod_alarm_timer`

## Requirements
- R1: Register map by `bus_addr`:
  - 0 is the control word: bit 0 overflow flag, bit 1 interrupt enable, bits [4:2] divider exponent, bits [6:5] clock select, all other bits read 0.
  - 1 is the count, 2 is the modulo value, 3 is the initial value. Each holds 16 bits in [15:0], and bits [31:16] read 0.
  - After reset: control 0, count 0, modulo 0xFFFF, initial 0.
- R2: On each prescaler pulse the count rises by one. When the count equals the modulo value, the pulse loads the initial value instead.
- R3: A write of any data to the count register loads the initial value on that clock edge. This write takes precedence over a pulse in the same cycle, and that pulse then sets no flag.
- R4: The flag sets on a pulse that moves the count from the modulo value to the initial value. It sets whether or not the interrupt enable is on.
- R5: The flag clears only when a control write with bit 0 = 0 follows a control read that returned bit 0 = 1.
  - Any control write removes that arming, and so does any overflow after the read.
  - Writing 1 to bit 0, or writing 0 without the arming, leaves the flag set.
  - An overflow in the same cycle as the write keeps the flag set.
- R6: `irq` is a register holding (flag AND enable) from the previous cycle.
- R7: Clock select:
  - 0 stops counting.
  - 1 advances the prescaler every cycle.
  - 2 advances it on cycles where `tick_en` is high.
  - 3 stops counting.
- R8: With divider exponent n, one pulse is issued per 2^n source cycles.
  - A control write that changes the select or the exponent restarts the prescaler, with no pulse in that cycle.
  - The first pulse after such a write comes a full 2^n source cycles later.
- R9: If the count is above the modulo value, counting continues to 0xFFFF. The next pulse loads the initial value without setting the flag, and the modulo value then matches on the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Fixed-frequency clock-enable tick |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
The counter is run from the system clock with a short modulo span, and from hand-placed ticks. The hand-placed ticks put the climb, the reload and the overflow on exact cycles. Tick runs at divider exponents 1 and 2, and a system-clock run at exponent 7, separate the divide ratio from the restart that a changed setting causes. The acknowledge is tried in several orders to tell a true handshake from a plain write-to-clear: a bare zero write, a one write, read then zero write, and read then a further overflow before the zero write. A modulo value written below the live count shows that the 0xFFFF wrap is silent, as opposed to an early match.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int          ADDR_W  = 2;
  localparam logic [1:0]  A_CTRL  = 2'd0;
  localparam logic [1:0]  A_COUNT = 2'd1;
  localparam logic [1:0]  A_MOD   = 2'd2;
  localparam logic [1:0]  A_INIT  = 2'd3;
  localparam int          B_FLAG  = 0;
  localparam int          B_IE    = 1;
  localparam int          B_DIV   = 2;

  typedef enum logic [1:0] {
    CS_OFF  = 2'd0,
    CS_SYS  = 2'd1,
    CS_TICK = 2'd2,
    CS_RSVD = 2'd3
  } clk_sel_e;
endpackage

// File: rtl/alarm_prescaler.sv
module alarm_prescaler
  import alarm_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  clk_sel_e        sel,
  input  logic [PS_W-1:0] div_exp,
  input  logic            tick_en,
  input  logic            restart,
  output logic            pulse
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic             src;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) limit[i] = (i < int'(div_exp));
  end

  assign src   = (sel == CS_SYS) || ((sel == CS_TICK) && tick_en);
  assign pulse = src && !restart && (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (src)     pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
  end

  AST_PULSE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (sel == CS_SYS || sel == CS_TICK)); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0)); // R8
  AST_NO_PULSE_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !pulse); // R8
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic             load,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic at_mod, at_top;

  assign at_mod = (cnt == mod_val);
  assign at_top = &cnt;
  assign ovf    = pulse && !load && at_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= init_val;
    else if (pulse) cnt <= (at_mod || at_top) ? init_val : cnt + 1'b1;
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && !at_mod && !at_top) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_RELOAD_AT_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && at_mod) |=> (cnt == $past(init_val))); // R2
  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(init_val))); // R3
  AST_SILENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && at_top && !at_mod) |=> (cnt == $past(init_val))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !load) |=> $stable(cnt)); // R7
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wr_zero,
  output logic flag
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else if (ovf) begin
      flag    <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (wr_zero && armed_q) flag <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_ctrl && flag) begin
      armed_q <= 1'b1;
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag); // R4
  AST_FLAG_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_ctrl && wr_zero && !ovf)); // R5
  AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed_q) |=> flag); // R5
endmodule

// File: rtl/mod_alarm_timer.sv
module mod_alarm_timer
  import alarm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CS_LSB = B_DIV + PS_W;

  logic             ie_q;
  logic [PS_W-1:0]  div_q;
  clk_sel_e         sel_q;
  logic [CNT_W-1:0] mod_q, init_q, cnt;
  logic             flag, ovf, pulse;
  logic             wr_ctrl, rd_ctrl, wr_cnt, wr_mod, wr_init, cfg_change;
  clk_sel_e         sel_new;
  logic [PS_W-1:0]  div_new;
  logic             unused_wbits;

  assign wr_ctrl = bus_req && bus_we && (bus_addr == A_CTRL);
  assign rd_ctrl = bus_req && !bus_we && (bus_addr == A_CTRL);
  assign wr_cnt  = bus_req && bus_we && (bus_addr == A_COUNT);
  assign wr_mod  = bus_req && bus_we && (bus_addr == A_MOD);
  assign wr_init = bus_req && bus_we && (bus_addr == A_INIT);

  assign sel_new    = clk_sel_e'(bus_wdata[CS_LSB +: 2]);
  assign div_new    = bus_wdata[B_DIV +: PS_W];
  assign cfg_change = wr_ctrl && ((sel_new != sel_q) || (div_new != div_q));
  assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      div_q  <= '0;
      sel_q  <= CS_OFF;
      mod_q  <= '1;
      init_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ie_q  <= bus_wdata[B_IE];
        div_q <= div_new;
        sel_q <= sel_new;
      end
      if (wr_mod)  mod_q  <= bus_wdata[CNT_W-1:0];
      if (wr_init) init_q <= bus_wdata[CNT_W-1:0];
    end
  end

  alarm_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .div_exp(div_q),
    .tick_en(tick_en), .restart(cfg_change), .pulse(pulse)
  );

  alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pulse(pulse), .load(wr_cnt),
    .mod_val(mod_q), .init_val(init_q), .cnt(cnt), .ovf(ovf)
  );

  alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .rd_ctrl(rd_ctrl),
    .wr_ctrl(wr_ctrl), .wr_zero(!bus_wdata[B_FLAG]), .flag(flag)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_FLAG]        = flag;
        bus_rdata[B_IE]          = ie_q;
        bus_rdata[B_DIV +: PS_W] = div_q;
        bus_rdata[CS_LSB +: 2]   = sel_q;
      end
      A_COUNT: bus_rdata[CNT_W-1:0] = cnt;
      A_MOD:   bus_rdata[CNT_W-1:0] = mod_q;
      default: bus_rdata[CNT_W-1:0] = init_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flag && ie_q;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |=> !irq); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ie_q) |=> irq); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_CTRL) |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R1
endmodule

// File: tb/sim_mod_alarm_timer.sv
`timescale 1ns/1ps
module sim_mod_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  logic [15:0] m_cnt, m_mod, m_init;
  logic        m_flag, m_ie, m_armed, m_irq;
  int          m_ps, m_cs, m_pre;

  always #4 clk = ~clk;

  mod_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_req(req), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return 32'(m_flag) | (32'(m_ie) << 1) | (32'(m_ps) << 2) | (32'(m_cs) << 5);
      2'd1:    return 32'(m_cnt);
      2'd2:    return 32'(m_mod);
      default: return 32'(m_init);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 16'hFFFF; m_init = 0;
      m_flag = 0; m_ie = 0; m_armed = 0; m_irq = 0;
      m_ps = 0; m_cs = 0; m_pre = 0;
    end else begin
      bit cfgw, cfgchg, src, pulse, load, ovf, irqn;
      int lim;
      cfgw   = req && we && addr == 2'd0;
      cfgchg = cfgw && ((int'(wdata[6:5]) != m_cs) || (int'(wdata[4:2]) != m_ps));
      src    = (m_cs == 1) || (m_cs == 2 && tick);
      lim    = (1 << m_ps) - 1;
      pulse  = 0;
      if (cfgchg) m_pre = 0;
      else if (src) begin
        if (m_pre == lim) begin pulse = 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
      load = req && we && addr == 2'd1;
      ovf  = 0;
      irqn = m_flag && m_ie;
      if (load) m_cnt = m_init;
      else if (pulse) begin
        if (m_cnt == m_mod) begin m_cnt = m_init; ovf = 1; end
        else if (m_cnt == 16'hFFFF) m_cnt = m_init;
        else m_cnt = m_cnt + 16'd1;
      end
      if (ovf) begin m_flag = 1; m_armed = 0; end
      else if (cfgw) begin
        if (!wdata[0] && m_armed) m_flag = 0;
        m_armed = 0;
      end else if (req && !we && addr == 2'd0 && m_flag) m_armed = 1;
      if (cfgw) begin m_ie = wdata[1]; m_ps = int'(wdata[4:2]); m_cs = int'(wdata[6:5]); end
      if (req && we && addr == 2'd2) m_mod = wdata[15:0];
      if (req && we && addr == 2'd3) m_init = wdata[15:0];
      m_irq = irqn;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(rdata === exp_rdata(addr), (addr == 2'd0) ? "R5 ctrl/flag" :
          (addr == 2'd1) ? "R2 count" : "R1 reg", rdata, exp_rdata(addr));
      chk(irq === m_irq, "R6 irq", 32'(irq), 32'(m_irq));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); req = 0; we = 0; addr = 2'd1; tick = 0; end
  endtask
  task automatic tk(input int n);
    repeat (n) begin @(negedge clk); req = 0; we = 0; addr = 2'd1; tick = 1; end
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; tick = 0;
  endtask
  task automatic rd_exp(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a; tick = 0;
    #2 chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_exp(2'd0, 32'h0, "R1 ctrl reset");
    rd_exp(2'd1, 32'h0, "R1 count reset");
    rd_exp(2'd2, 32'hFFFF, "R1 modulo reset");
    rd_exp(2'd3, 32'h0, "R1 initial reset");
    chk(irq === 1'b0, "R6 irq reset", 32'(irq), 0);
    // R3 load from initial, R1 upper bits read zero
    wr(2'd3, 32'h2);
    wr(2'd2, 32'hFFFF0005);
    rd_exp(2'd2, 32'h5, "R1 upper bits zero");
    wr(2'd1, 32'hABCD);
    rd_exp(2'd1, 32'h2, "R3 count write loads initial");
    // R4 flag with interrupt disabled
    wr(2'd0, 32'h20);
    idle(20);
    wr(2'd0, 32'h0);
    idle(1);
    chk(irq === 1'b0, "R6 masked irq", 32'(irq), 0);
    rd_exp(2'd0, 32'h1, "R4 flag set with enable off / R5 zero write unarmed");
    wr(2'd0, 32'h1);
    rd_exp(2'd0, 32'h1, "R5 write one no effect");
    wr(2'd0, 32'h0);
    rd_exp(2'd0, 32'h0, "R5 read-then-zero clears");
    // R7 stop encodings
    c = m_cnt;
    idle(5);
    rd_exp(2'd1, 32'(c), "R7 select 0 holds");
    wr(2'd0, 32'h60);
    idle(8);
    rd_exp(2'd1, 32'(c), "R7 select 3 holds");
    // R6 interrupt
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h22);
    idle(10);
    chk(irq === 1'b1, "R6 irq asserted", 32'(irq), 1);
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h00);
    idle(2);
    chk(irq === 1'b0, "R6 irq drops after enable off", 32'(irq), 0);
    rd_exp(2'd0, 32'h1, "R5 flag kept");
    wr(2'd0, 32'h0);
    rd_exp(2'd0, 32'h0, "R5 cleared");
    // R2/R4 tick source, divide by 1
    wr(2'd0, 32'h40);
    wr(2'd1, 32'h0);
    tk(3);
    rd_exp(2'd1, 32'h5, "R2 climb to modulo");
    rd_exp(2'd0, 32'h40, "R4 no flag before transition");
    tk(1);
    rd_exp(2'd1, 32'h2, "R2 reload to initial");
    rd_exp(2'd0, 32'h41, "R4 flag on modulo to initial");
    // R5 overflow between read and write keeps flag
    tk(4);
    wr(2'd0, 32'h40);
    rd_exp(2'd0, 32'h41, "R5 overflow after read keeps flag");
    wr(2'd0, 32'h40);
    rd_exp(2'd0, 32'h40, "R5 clear after fresh read");
    // R8 prescaler
    wr(2'd0, 32'h48);
    wr(2'd1, 32'h0);
    tk(3);
    rd_exp(2'd1, 32'h2, "R8 div4 not yet");
    tk(1);
    rd_exp(2'd1, 32'h3, "R8 div4 fourth tick");
    tk(2);
    wr(2'd0, 32'h44);
    tk(1);
    rd_exp(2'd1, 32'h3, "R8 restart on change");
    tk(1);
    rd_exp(2'd1, 32'h4, "R8 div2 full period");
    wr(2'd0, 32'h3C);
    wr(2'd1, 32'h0);
    idle(126);
    rd_exp(2'd1, 32'h2, "R8 div128 before period");
    rd_exp(2'd1, 32'h3, "R8 div128 after period");
    // R9 modulo below count
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h10);
    wr(2'd2, 32'hFFFF);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h20);
    idle(40);
    wr(2'd2, 32'h18);
    idle(1);
    while (m_cnt != 16'hFFFF) idle(1);
    while (m_cnt != 16'h12) idle(1);
    wr(2'd0, 32'h0);
    rd_exp(2'd0, 32'h0, "R9 wrap at 0xFFFF sets no flag");
    rd_exp(2'd1, 32'h13, "R9 wrap reloads initial");
    wr(2'd0, 32'h20);
    idle(12);
    rd_exp(2'd0, 32'h21, "R9 modulo matches on next pass");
    idle(4);
    summary();
  end
endmodule